// File: doc/BRIEF.md
# Switchable-Length Synchronous Serial Port

This block is a clocked serial shift port with a data input, a data output and a clock line that can be driven or received. Each transfer moves either 4 or 8 bits, most significant bit first. A mode register selects the length and the clock source. In internal mode the port makes its own shift clock from an instruction-cycle strobe and drives the clock line. In external mode it follows a clock pin, which it resynchronises to the system clock.

Software writes the mode register and then the shift register. While the port is enabled, writing the shift register starts a transfer. When the last bit has been sampled, a sticky completion flag is raised. A single interrupt request output carries either that flag or an external interrupt pin, and a select bit in the mode register chooses which one.

Top module: `syncser_port`

## Requirements
- R1: After reset the port is disabled (all mode bits 0), the clock output is high and not driven (`sck_oe`=0), `sdo` is 1, the completion flag is 0, and `irq` follows `ext_int`.
- R2: The mode register is written whole through `mode_wdata`. Bit 0 enables the port, bit 1 selects the length (1 = 8 bits, 0 = 4 bits), bit 2 selects the clock source (1 = external pin, 0 = internal) and bit 3 selects the interrupt source (1 = completion flag, 0 = `ext_int`).
- R3: Writing the shift register while the port is enabled starts a transfer and clears the completion flag in the same cycle. While the port is disabled, the write only loads the data: no clock edge appears and the flag does not change.
- R4: With the internal clock, `sck_out` falls when the transfer starts, stays low for 32 instruction-cycle ticks, then stays high for 32 ticks, giving a period of 64 ticks. Between transfers it rests high.
- R5: Data leaves MSB first. The first bit is on `sdo` from the start of the transfer, and with the internal clock `sdo` changes only at a start or together with a falling clock edge.
- R6: On each rising clock edge the port samples `sdi` into bit 0 and shifts the active bits up by one. At the end of the transfer, `shreg_rdata` holds the received bits.
- R7: In 4-bit mode only bits 3:0 take part in the transfer (bit 3 goes out first). Bits 7:4 keep their written value, and the transfer ends after 4 rising edges. In 8-bit mode it ends after 8.
- R8: The completion flag is set on the final rising edge and stays set until `flag_clr` is pulsed or a new transfer starts. Setting the flag takes priority over clearing it.
- R9: `irq` equals the completion flag when bit 3 of the mode register is 1, and equals `ext_int` when it is 0.
- R10: `sck_oe` is high only in internal-clock mode while the port is enabled. In external mode, `sck_in` passes through a two-flop synchroniser, and the port shifts on edges of the synchronised signal.
- R11: Clearing the enable bit during a transfer aborts it. The clock returns high, no further edges follow, and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One-cycle strobe once per instruction cycle |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 4 | Mode value: {irq source, clock source, length, enable} |
| shreg_we | input | 1 | Write strobe for the shift register, starts a transfer when enabled |
| shreg_wdata | input | 8 | Data to transmit |
| shreg_rdata | output | 8 | Current shift register contents |
| flag_clr | input | 1 | Clears the completion flag |
| done_flag | output | 1 | Sticky transfer-complete flag |
| sck_in | input | 1 | Serial clock from the pin (external mode) |
| sck_out | output | 1 | Serial clock to the pin (internal mode), idle high |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ext_int | input | 1 | External interrupt pin, assumed synchronous to `clk` |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench targets the following corner cases, each paired with the symptom a faulty design would show:

- **Bit order and timing.** An inverted bit order shows up as a wrong `sdo` value at the rising edges. A mis-sized divider shows up as low or high phases that are not 32 ticks long.
- **4-bit mode.** A design that shifts all 8 bits corrupts the upper nibble, and one that miscounts the length gives the wrong number of clock edges or a flag that arrives late or never.
- **Disabled writes and abort.** A disabled write that still starts a transfer, or an abort that leaves the clock low or sets the flag, is visible at `sck_out` and `done_flag`.
- **Flag and interrupt handling.** A flag that clears by itself, or a start that fails to clear it, is caught. So is an interrupt select that is wired backwards, which routes the wrong source to `irq`.
- **External clock.** In external mode, a lost synchroniser stage or a sample on the wrong edge corrupts the received byte.

// File: rtl/syncser_pkg.sv
// Shared types for the serial port: the layout of the mode register.
// Assumes software writes the whole register at once.
package syncser_pkg;
    // Field order is fixed by software decode: bit0 enable, bit1 length,
    // bit2 clock source, bit3 interrupt source.
    typedef struct packed {
        logic irq_sel;   // 1: completion flag drives irq, 0: ext_int
        logic ext_clk;   // 1: external clock pin, 0: internal divider
        logic len8;      // 1: 8-bit transfer, 0: 4-bit transfer
        logic enable;    // 1: serial function on
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/syncser_edge_gen.sv
// Clock generation and edge detection for the serial port.
// Internal mode: counts instruction-cycle ticks and toggles the clock every
// HALF_TICKS ticks during a transfer; the line falls at start.
// External mode: two-flop synchroniser plus one history flop on sck_in.
// Emits one-cycle rise/fall pulses only while a transfer is active.
module syncser_edge_gen #(
    parameter int HALF_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ext_clk,
    input  logic active,
    input  logic start,
    input  logic cyc_tick,
    input  logic sck_in,
    output logic sck_level,
    output logic rise,
    output logic fall
);
    localparam int TICK_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

    logic [TICK_W-1:0] tick_cnt;
    logic              sck_q;
    logic [2:0]        sync_q;
    logic              half_done;
    logic              int_rise, int_fall, ext_rise, ext_fall;

    assign half_done = cyc_tick && (tick_cnt == TICK_W'(HALF_TICKS - 1));

    // Internal divider: start pulls the line low, ticks toggle it, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b1;
            tick_cnt <= '0;
        end else if (start && !ext_clk) begin
            sck_q    <= 1'b0;
            tick_cnt <= '0;
        end else if (!active || ext_clk || !enable) begin
            sck_q    <= 1'b1;
            tick_cnt <= '0;
        end else if (cyc_tick) begin
            if (half_done) begin
                tick_cnt <= '0;
                sck_q    <= ~sck_q;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // Synchroniser for the external clock; bit 2 keeps history for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], sck_in};
    end

    // Edge pulses from whichever source is selected.
    always_comb begin
        int_rise = half_done && !sck_q;
        int_fall = half_done && sck_q;
        ext_rise = sync_q[1] && !sync_q[2];
        ext_fall = !sync_q[1] && sync_q[2];
        rise = !start && enable && active && (ext_clk ? ext_rise : int_rise);
        fall = !start && enable && active && (ext_clk ? ext_fall : int_fall);
    end

    assign sck_level = sck_q;
endmodule

// File: rtl/syncser_bit_counter.sv
// Counts sampled bits of a transfer and signals its end.
// Assumes rise pulses arrive only while enabled and not at a start.
// The end test uses >= so a length change mid-transfer still terminates.
module syncser_bit_counter #(
    parameter int DATA_W  = 8,
    parameter int SHORT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic rise,
    input  logic len8,
    output logic active,
    output logic done
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] last_idx;
    logic             is_last;

    assign last_idx = len8 ? CNT_W'(DATA_W - 1) : CNT_W'(SHORT_W - 1);
    assign is_last  = (bit_cnt >= last_idx);
    assign done     = rise && active && is_last;

    // Transfer state: armed by start, dropped on the final edge or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bit_cnt <= '0;
        end else if (start) begin
            active  <= 1'b1;
            bit_cnt <= '0;
        end else if (!enable) begin
            active  <= 1'b0;
        end else if (rise && active) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (is_last) active <= 1'b0;
        end
    end
endmodule

// File: rtl/syncser_shift_unit.sv
// Shift register and output data flop.
// Rise shifts sdi into bit 0; in short mode bits above SHORT_W-1 hold.
// sdo is a separate flop loaded with the MSB at start and at each fall,
// so it is steady across the sampling edge.
module syncser_shift_unit #(
    parameter int DATA_W  = 8,
    parameter int SHORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              start,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    input  logic              len8,
    output logic [DATA_W-1:0] data,
    output logic              sdo
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] nxt;
    logic              cur_msb, load_msb;

    // Per-bit next value: bit 0 takes sdi, upper bits hold in short mode.
    for (genvar i = 0; i < DATA_W; i++) begin : g_stage
        if (i == 0) begin : g_in
            assign nxt[i] = sdi;
        end else if (i >= SHORT_W) begin : g_upper
            assign nxt[i] = len8 ? sh_q[i-1] : sh_q[i];
        end else begin : g_lower
            assign nxt[i] = sh_q[i-1];
        end
    end

    assign cur_msb  = len8 ? sh_q[DATA_W-1]  : sh_q[SHORT_W-1];
    assign load_msb = len8 ? wdata[DATA_W-1] : wdata[SHORT_W-1];

    // Shift register: software load wins, otherwise shift on rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh_q <= '0;
        else if (load) sh_q <= wdata;
        else if (rise) sh_q <= nxt;
    end

    // Output bit: first bit at start, next bit after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     sdo <= 1'b1;
        else if (start) sdo <= load_msb;
        else if (fall)  sdo <= cur_msb;
    end

    assign data = sh_q;
endmodule

// File: rtl/syncser_port.sv
// Top of the switchable-length synchronous serial port.
// Holds the mode register and completion flag, muxes the shared interrupt.
// Assumes ext_int is already synchronous to clk and cyc_tick is one cycle.
module syncser_port
    import syncser_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SHORT_W    = 4,
    parameter int HALF_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              shreg_we,
    input  logic [DATA_W-1:0] shreg_wdata,
    output logic [DATA_W-1:0] shreg_rdata,
    input  logic              flag_clr,
    output logic              done_flag,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    input  logic              ext_int,
    output logic              irq
);
    mode_t mode_q;
    logic  start, active, rise, fall, done, flag_q;

    assign start = shreg_we && mode_q.enable;

    // Mode register, written whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_t'(mode_wdata);
    end

    // Completion flag: set on the last edge, cleared by software or start.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (done)                flag_q <= 1'b1;
        else if (start || flag_clr)   flag_q <= 1'b0;
    end

    syncser_edge_gen #(.HALF_TICKS(HALF_TICKS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode_q.enable),
        .ext_clk   (mode_q.ext_clk),
        .active    (active),
        .start     (start),
        .cyc_tick  (cyc_tick),
        .sck_in    (sck_in),
        .sck_level (sck_out),
        .rise      (rise),
        .fall      (fall)
    );

    syncser_bit_counter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mode_q.enable),
        .start  (start),
        .rise   (rise),
        .len8   (mode_q.len8),
        .active (active),
        .done   (done)
    );

    syncser_shift_unit #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (shreg_we),
        .start (start),
        .wdata (shreg_wdata),
        .rise  (rise),
        .fall  (fall),
        .sdi   (sdi),
        .len8  (mode_q.len8),
        .data  (shreg_rdata),
        .sdo   (sdo)
    );

    assign done_flag = flag_q;
    assign sck_oe    = mode_q.enable && !mode_q.ext_clk;
    assign irq       = mode_q.irq_sel ? flag_q : ext_int;
endmodule

// File: rtl/syncser_port_checker.sv
// Temporal checks on the serial port, attached by bind.
// mode_bits: bit0 enable, bit2 external clock.
module syncser_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       shreg_we,
    input logic       flag_clr,
    input logic       cyc_tick,
    input logic [3:0] mode_bits,
    input logic       done_flag,
    input logic       sck_out,
    input logic       sdo
);
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bits[0] && $past(!mode_bits[0])) |-> sck_out);

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shreg_we && mode_bits[0]) |=> !done_flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr && !(shreg_we && mode_bits[0])) |=> done_flag);

    assert_sdo_at_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && !$past(shreg_we && mode_bits[0]) && !$past(mode_bits[2]))
        |-> $fell(sck_out));

    assert_sck_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck_out) |-> ($past(cyc_tick) || $past(shreg_we) ||
                               $past(!mode_bits[0]) || $past(mode_bits[2])));

    assert_flag_with_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($rose(sck_out) || $past(mode_bits[2])));
endmodule

bind syncser_port syncser_port_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shreg_we  (shreg_we),
    .flag_clr  (flag_clr),
    .cyc_tick  (cyc_tick),
    .mode_bits (mode_q),
    .done_flag (done_flag),
    .sck_out   (sck_out),
    .sdo       (sdo)
);

// File: tb/syncser_port_test.sv
// Scoreboard bench: driver tasks queue the expected output bits, a monitor
// pops and compares them at each rising serial clock and times the phases.
module syncser_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = '0;
    logic       shreg_we = 1'b0;
    logic [7:0] shreg_wdata = '0;
    logic [7:0] shreg_rdata;
    logic       flag_clr = 1'b0;
    logic       done_flag;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe;
    logic       sdi = 1'b1;
    logic       sdo;
    logic       ext_int = 1'b0;
    logic       irq;

    always #5 clk = ~clk;

    syncser_port uut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .shreg_we(shreg_we), .shreg_wdata(shreg_wdata), .shreg_rdata(shreg_rdata),
        .flag_clr(flag_clr), .done_flag(done_flag),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .ext_int(ext_int), .irq(irq)
    );

    int   checks = 0;
    int   fails = 0;
    bit   exp_q[$];
    int   rise_cnt = 0;
    int   since = 0;
    bit   ext_test = 1'b0;
    logic [7:0] rx_vec = '0;
    int   rx_len = 8;
    int   rx_idx = 0;
    int   div = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Instruction-cycle strobe: one tick every 4 clocks.
    initial forever begin
        @(posedge clk); #1;
        cyc_tick = (div == 3);
        div = (div + 1) % 4;
    end

    // Monitor: scoreboard on rising line, phase timing, remote sdi model.
    initial begin
        logic line, prev_line;
        prev_line = 1'b1;
        forever begin
            @(negedge clk);
            line = ext_test ? sck_in : sck_out;
            if (line && !prev_line) begin
                rise_cnt++;
                if (exp_q.size() == 0) check("R5", "unexpected clock edge", 1, 0);
                else check("R5", "sdo bit at rise", sdo, exp_q.pop_front());
                if (!ext_test) check("R4", "low phase ticks", since, 32);
                since = 0;
            end else if (!line && prev_line) begin
                if (!ext_test && since < 48) check("R4", "high phase ticks", since, 32);
                since = 0;
                if (rx_idx < rx_len) begin
                    sdi = rx_vec[rx_len - 1 - rx_idx];
                    rx_idx++;
                end
            end
            if (cyc_tick) since++;
            prev_line = line;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        check("R8", "watchdog expired", 1, 0);
        finish_run();
    end

    task automatic wr_mode(input logic [3:0] m);
        @(posedge clk); #1; mode_we = 1'b1; mode_wdata = m;
        @(posedge clk); #1; mode_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(posedge clk); #1; shreg_we = 1'b1; shreg_wdata = d;
        @(posedge clk); #1; shreg_we = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(posedge clk);
    endtask

    task automatic wait_flag(input string req);
        int n = 0;
        while (!done_flag && n < 20000) begin @(negedge clk); n++; end
        check(req, "completion flag raised", done_flag, 1);
        @(negedge clk);
    endtask

    task automatic setup_xfer(input bit len8, input logic [7:0] tx, input logic [7:0] rx);
        int len = len8 ? 8 : 4;
        for (int i = 0; i < len; i++) exp_q.push_back(tx[len - 1 - i]);
        rx_vec = rx; rx_len = len; rx_idx = 0; rise_cnt = 0;
    endtask

    task automatic finish_xfer(input bit len8, input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] want = len8 ? rx : {tx[7:4], rx[3:0]};
        wait_flag("R8");
        check(len8 ? "R6" : "R7", "edge count", rise_cnt, len8 ? 8 : 4);
        check(len8 ? "R6" : "R7", "received data", shreg_rdata, want);
        check("R5", "scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic xfer_int(input bit len8, input logic [7:0] tx, input logic [7:0] rx);
        setup_xfer(len8, tx, rx);
        wr_data(tx);
        @(negedge clk);
        check("R3", "start clears flag", done_flag, 0);
        finish_xfer(len8, tx, rx);
        wait_ticks(60);
    endtask

    task automatic xfer_ext(input bit len8, input logic [7:0] tx, input logic [7:0] rx);
        int len = len8 ? 8 : 4;
        setup_xfer(len8, tx, rx);
        wr_data(tx);
        repeat (10) @(posedge clk);
        check("R10", "no progress without external clock", rise_cnt, 0);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1; sck_in = 1'b0;
            repeat (8) @(posedge clk);
            #1; sck_in = 1'b1;
            repeat (8) @(posedge clk);
        end
        finish_xfer(len8, tx, rx);
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", "sck_out idle", sck_out, 1);
        check("R1", "sck_oe off", sck_oe, 0);
        check("R1", "flag clear", done_flag, 0);
        check("R1", "sdo idle", sdo, 1);
        check("R1", "irq follows ext_int low", irq, 0);
        @(posedge clk); #1; ext_int = 1'b1;
        @(negedge clk);
        check("R1", "irq follows ext_int high", irq, 1);
        @(posedge clk); #1; ext_int = 1'b0; rst_n = 1'b1;

        // R3: write while disabled only loads
        rise_cnt = 0;
        wr_data(8'h5A);
        wait_ticks(80);
        @(negedge clk);
        check("R3", "no clock when disabled", rise_cnt, 0);
        check("R3", "sck stays high when disabled", sck_out, 1);
        check("R3", "flag untouched when disabled", done_flag, 0);
        check("R3", "data loaded when disabled", shreg_rdata, 8'h5A);

        // R2/R10: enable, 8-bit, internal clock
        wr_mode(4'b0011);
        @(negedge clk);
        check("R10", "sck_oe in internal mode", sck_oe, 1);
        xfer_int(1'b1, 8'hA5, 8'h3C);

        // R9/R8: interrupt source select and sticky flag
        @(posedge clk); #1; ext_int = 1'b0;
        @(negedge clk);
        check("R9", "irq from ext pin while flag set", irq, 0);
        wr_mode(4'b1011);
        @(negedge clk);
        check("R2", "irq from flag after select", irq, 1);
        wait_ticks(100);
        @(negedge clk);
        check("R8", "flag sticky", done_flag, 1);
        @(posedge clk); #1; ext_int = 1'b1; flag_clr = 1'b1;
        @(posedge clk); #1; flag_clr = 1'b0;
        @(negedge clk);
        check("R8", "flag cleared by software", done_flag, 0);
        check("R9", "irq ignores ext pin when flag selected", irq, 0);
        @(posedge clk); #1; ext_int = 1'b0;

        // Second 8-bit pattern, then a start with the flag already set
        xfer_int(1'b1, 8'h81, 8'h7E);
        xfer_int(1'b1, 8'h3B, 8'hC4);

        // R7: 4-bit mode
        wr_mode(4'b1001);
        xfer_int(1'b0, 8'hB6, 8'h09);
        xfer_int(1'b0, 8'h69, 8'h0A);

        // R11: abort mid-transfer
        wr_mode(4'b1011);
        exp_q.push_back(1'b1);
        rx_vec = 8'hFF; rx_len = 8; rx_idx = 0; rise_cnt = 0;
        wr_data(8'hC3);
        begin
            int n = 0;
            while (rise_cnt < 1 && n < 5000) begin @(negedge clk); n++; end
        end
        wait_ticks(10);
        wr_mode(4'b1010);
        repeat (3) @(negedge clk);
        check("R11", "clock high after abort", sck_out, 1);
        wait_ticks(200);
        @(negedge clk);
        check("R11", "no edges after abort", rise_cnt, 1);
        check("R11", "no flag after abort", done_flag, 0);

        // R10: external clock, 8 and 4 bits
        ext_test = 1'b1;
        wr_mode(4'b1111);
        @(negedge clk);
        check("R10", "sck_oe off in external mode", sck_oe, 0);
        xfer_ext(1'b1, 8'h4E, 8'hD2);
        check("R9", "irq from flag in external mode", irq, 1);
        wr_mode(4'b1101);
        xfer_ext(1'b0, 8'h3C, 8'h05);

        finish_run();
    end
endmodule